// File: doc/BRIEF.md
# Region Address Decoder with Rotation

This block sits between a processor load/store unit and a set of on-chip memories. It takes one request at a time, made of a 32-bit address, an access size and a read/write flag. From the top eight address bits it picks one target: boot ROM, instruction tightly-coupled memory (TCM), data TCM, main RAM, shared working RAM, private working RAM or the I/O space. It then drives a one-hot select, a masked offset, byte enables and write data toward that target. The memories respond through one shared read-data input, and the fabric places the selected target's word on it in the same cycle.

On reads the block shapes the returned data. Unaligned words and halfwords are rotated rather than faulted. Bytes are taken from their lane. A word read from the halfword-wide I/O space takes two back-to-back halfword accesses. Every response carries a wait-cycle count. An access that maps to nothing returns a defined value and raises an error flag. The instruction TCM window size and the shared RAM size come from static control inputs.

Top module: `addr_region_decoder`

## Requirements
- R1: The region code is req_addr[31:24]. Codes 0x00 and 0x01 both select instruction TCM, 0x02 main RAM, 0x03 working RAM, 0x04 I/O and 0xFF boot ROM. An issued access raises exactly one mem_sel bit, with index ROM=0, ITCM=1, DTCM=2, RAM=3, SHR=4, PRV=5, IO=6.
- R2: Instruction TCM is selected only when req_addr < (512 << itcm_size_fld). Otherwise the access is unmapped. Its offset is req_addr masked to 32 KiB.
- R3: Inside the main RAM code, an address whose bits above the 16 KiB offset equal 0x027C0000 goes to data TCM with a 14-bit offset. The data TCM wins over main RAM.
- R4: Any other main-RAM-code address goes to main RAM with offset req_addr & 0x3FFFFF.
- R5: In working RAM, an address at or above 0x03800000, or any address when shr_size is zero, goes to private RAM with offset masked to 64 KiB. All others go to shared RAM with offset req_addr & (shr_size-1).
- R6: The I/O offset is req_addr & 0xFFFFFF, and I/O data is in mem_rdata[15:0]. A word I/O read issues the word-aligned offset first and that offset OR 2 in the next cycle, with req_ready low during the second access. The second result forms bits [31:16].
- R7: A word read returns the word rotated right by 8*req_addr[1:0].
- R8: A halfword read takes the upper half of the memory word when addr[1] is 1 and rotates it right by 8*addr[0]. A byte read returns the addressed lane zero-extended. For I/O, only addr[0] picks the half of the I/O halfword.
- R9: A fetch (req_fetch=1) to an unmapped address, or to boot ROM while rom_present is 0, returns 0xE710B710 with rsp_err set.
- R10: rsp_wait is 2 for every read response and 1 for every write response.
- R11: A write to an unmapped address or to boot ROM raises no mem_sel or mem_we bit and sets rsp_err. A non-fetch unmapped read returns zero with rsp_err set.
- R12: Every accepted access other than a word I/O read responds with rsp_valid in the cycle after acceptance. A word I/O read responds two cycles after acceptance.
- R13: req_size encodes 0 byte, 1 halfword, 2 word. mem_be is 4'hF for a word, 4'h3 or 4'hC by addr[1] for a halfword, and 1<<addr[1:0] for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| itcm_size_fld | input | 5 | Instruction TCM window size shift |
| shr_size | input | 17 | Shared working RAM size in bytes (power of two or zero) |
| rom_present | input | 1 | Boot ROM is populated |
| mem_sel | output | 7 | One-hot target select |
| mem_addr | output | 32 | Masked target offset |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data to target |
| mem_rdata | input | 32 | Read data from the selected target |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Formatted read data |
| rsp_wait | output | 2 | Wait cycles of the access |
| rsp_err | output | 1 | Access was unmapped or dropped |

## Verification
The second half of a split I/O word read can fall in the same cycle as a new request that is already waiting on the inputs. The bench provokes this by presenting the next request right after an unaligned word I/O read. While req_ready is low it checks that mem_sel and mem_addr point at the upper I/O halfword and not at the waiting request. It then checks that the rotated, combined word arrives first and that the waiting request is issued and answered in the cycles after it. The same overlap happens between each registered response and the decode of the next back-to-back request, and the in-order scoreboard judges this case.

// File: rtl/rgd_pkg.sv
`timescale 1ns/1ps
package rgd_pkg;
  typedef enum logic [2:0] {
    TG_ROM  = 3'd0,
    TG_ITCM = 3'd1,
    TG_DTCM = 3'd2,
    TG_RAM  = 3'd3,
    TG_SHR  = 3'd4,
    TG_PRV  = 3'd5,
    TG_IO   = 3'd6,
    TG_NONE = 3'd7
  } tgt_e;

  localparam int NTGT = 7;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [31:0] TRAP_WORD = 32'hE710_B710;
endpackage

// File: rtl/rgd_region_dec.sv
`timescale 1ns/1ps
module rgd_region_dec
  import rgd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned FLD_W      = 5,
  parameter int unsigned SHR_W      = 17,
  parameter logic [7:0]  CODE_ROM   = 8'hFF,
  parameter logic [7:0]  CODE_ITCM  = 8'h00,
  parameter logic [7:0]  CODE_ITCMM = 8'h01,
  parameter logic [7:0]  CODE_RAM   = 8'h02,
  parameter logic [7:0]  CODE_WRAM  = 8'h03,
  parameter logic [7:0]  CODE_IO    = 8'h04,
  parameter logic [ADDR_W-1:0] DTCM_BASE = 32'h027C_0000,
  parameter logic [ADDR_W-1:0] PRV_BASE  = 32'h0380_0000,
  parameter int unsigned ITCM_BYTES = 32768,
  parameter int unsigned DTCM_BYTES = 16384,
  parameter int unsigned RAM_BYTES  = 4194304,
  parameter int unsigned PRV_BYTES  = 65536,
  parameter int unsigned ROM_BYTES  = 16384,
  parameter int unsigned IO_BITS    = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FLD_W-1:0]  itcm_fld_i,
  input  logic [SHR_W-1:0]  shr_size_i,
  input  logic              rom_present_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] off_o
);
  localparam int unsigned CODE_LSB = ADDR_W - 8;
  localparam int unsigned LIM_W    = 9 + (2 ** FLD_W);
  localparam logic [ADDR_W-1:0] ITCM_MASK = ADDR_W'(ITCM_BYTES - 1);
  localparam logic [ADDR_W-1:0] DTCM_MASK = ADDR_W'(DTCM_BYTES - 1);
  localparam logic [ADDR_W-1:0] RAM_MASK  = ADDR_W'(RAM_BYTES - 1);
  localparam logic [ADDR_W-1:0] PRV_MASK  = ADDR_W'(PRV_BYTES - 1);
  localparam logic [ADDR_W-1:0] ROM_MASK  = ADDR_W'(ROM_BYTES - 1);
  localparam logic [ADDR_W-1:0] IO_MASK   = ADDR_W'((64'd1 << IO_BITS) - 64'd1);

  logic [7:0]        code;
  logic [LIM_W-1:0]  itcm_lim;
  logic              itcm_in;
  logic              dtcm_hit;
  logic [ADDR_W-1:0] shr_mask;

  assign code     = addr_i[ADDR_W-1:CODE_LSB];
  assign itcm_lim = LIM_W'(512) << itcm_fld_i;
  assign itcm_in  = LIM_W'(addr_i) < itcm_lim;
  assign dtcm_hit = (addr_i & ~DTCM_MASK) == DTCM_BASE;
  assign shr_mask = ADDR_W'(shr_size_i) - ADDR_W'(1);

  always_comb begin
    tgt_o = TG_NONE;
    off_o = '0;
    if (code == CODE_ITCM || code == CODE_ITCMM) begin
      if (itcm_in) begin
        tgt_o = TG_ITCM;
        off_o = addr_i & ITCM_MASK;
      end
    end else if (code == CODE_RAM) begin
      // data TCM overlays main RAM and is tested first
      if (dtcm_hit) begin
        tgt_o = TG_DTCM;
        off_o = addr_i & DTCM_MASK;
      end else begin
        tgt_o = TG_RAM;
        off_o = addr_i & RAM_MASK;
      end
    end else if (code == CODE_WRAM) begin
      if (addr_i >= PRV_BASE || shr_size_i == '0) begin
        tgt_o = TG_PRV;
        off_o = addr_i & PRV_MASK;
      end else begin
        tgt_o = TG_SHR;
        off_o = addr_i & shr_mask;
      end
    end else if (code == CODE_IO) begin
      tgt_o = TG_IO;
      off_o = addr_i & IO_MASK;
    end else if (code == CODE_ROM) begin
      if (rom_present_i) begin
        tgt_o = TG_ROM;
        off_o = addr_i & ROM_MASK;
      end
    end
  end
endmodule

// File: rtl/rgd_rd_fmt.sv
`timescale 1ns/1ps
module rgd_rd_fmt
  import rgd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        lane_i,
  input  logic              io_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HW = DATA_W / 2;

  logic [HW-1:0]       half;
  logic [1:0]          blane;
  logic [7:0]          bsel;
  logic [DATA_W-1:0]   rot_src;
  logic [1:0]          rot_amt;
  logic [2*DATA_W-1:0] dbl;

  // I/O data is halfword wide: only lane bit 0 matters there
  assign half  = (!io_i && lane_i[1]) ? word_i[DATA_W-1:HW] : word_i[HW-1:0];
  assign blane = io_i ? {1'b0, lane_i[0]} : lane_i;
  assign bsel  = word_i[8*blane +: 8];

  always_comb begin
    if (size_i == SZ_WORD) begin
      rot_src = word_i;
      rot_amt = lane_i;
    end else begin
      rot_src = {{HW{1'b0}}, half};
      rot_amt = {1'b0, lane_i[0]};
    end
  end

  assign dbl = {rot_src, rot_src} >> (8 * rot_amt);

  always_comb begin
    if (size_i == SZ_BYTE) data_o = {{(DATA_W-8){1'b0}}, bsel};
    else                   data_o = dbl[DATA_W-1:0];
  end
endmodule

// File: rtl/addr_region_decoder.sv
`timescale 1ns/1ps
module addr_region_decoder
  import rgd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FLD_W    = 5,
  parameter int unsigned SHR_W    = 17,
  parameter int unsigned WAIT_W   = 2,
  parameter int unsigned LD_WAIT  = 2,
  parameter int unsigned ST_WAIT  = 1,
  parameter logic [ADDR_W-1:0] DTCM_BASE = 32'h027C_0000,
  parameter logic [ADDR_W-1:0] PRV_BASE  = 32'h0380_0000,
  parameter int unsigned ITCM_BYTES = 32768,
  parameter int unsigned DTCM_BYTES = 16384,
  parameter int unsigned RAM_BYTES  = 4194304,
  parameter int unsigned PRV_BYTES  = 65536,
  parameter int unsigned ROM_BYTES  = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_fetch,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [FLD_W-1:0]  itcm_size_fld,
  input  logic [SHR_W-1:0]  shr_size,
  input  logic              rom_present,
  output logic [NTGT-1:0]   mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [WAIT_W-1:0] rsp_wait,
  output logic              rsp_err
);
  localparam int unsigned HW    = DATA_W / 2;
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned LIM_W = 9 + (2 ** FLD_W);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  tgt_e              dec_tgt;
  logic [ADDR_W-1:0] dec_off;

  rgd_region_dec #(
    .ADDR_W(ADDR_W), .FLD_W(FLD_W), .SHR_W(SHR_W),
    .DTCM_BASE(DTCM_BASE), .PRV_BASE(PRV_BASE),
    .ITCM_BYTES(ITCM_BYTES), .DTCM_BYTES(DTCM_BYTES), .RAM_BYTES(RAM_BYTES),
    .PRV_BYTES(PRV_BYTES), .ROM_BYTES(ROM_BYTES)
  ) u_dec (
    .addr_i       (req_addr),
    .itcm_fld_i   (itcm_size_fld),
    .shr_size_i   (shr_size),
    .rom_present_i(rom_present),
    .tgt_o        (dec_tgt),
    .off_o        (dec_off)
  );

  // state
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] hold_off_q, hold_off_d;
  logic [1:0]        hold_lane_q, hold_lane_d;
  logic [HW-1:0]     lo_q, lo_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;
  logic [WAIT_W-1:0] rsp_wait_q, rsp_wait_d;
  logic              rsp_err_q, rsp_err_d;

  logic accept, blocked, io_split, issue;
  logic [BE_W-1:0] be;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign blocked   = (dec_tgt == TG_NONE) || (req_we && dec_tgt == TG_ROM);
  assign io_split  = accept && !req_we && dec_tgt == TG_IO && req_size == SZ_WORD;
  assign issue     = accept && !blocked;

  always_comb begin
    if (req_size == SZ_WORD)      be = '1;
    else if (req_size == SZ_HALF) be = req_addr[1] ? BE_W'(4'hC) : BE_W'(4'h3);
    else                          be = BE_W'(1) << req_addr[1:0];
  end

  // read formatting
  logic [DATA_W-1:0] fmt_word, fmt_out;
  logic [1:0]        fmt_size, fmt_lane;
  logic              fmt_io;

  always_comb begin
    if (busy_q) begin
      fmt_word = {mem_rdata[HW-1:0], lo_q};
      fmt_size = SZ_WORD;
      fmt_lane = hold_lane_q;
      fmt_io   = 1'b1;
    end else begin
      fmt_word = (dec_tgt == TG_IO) ? {{HW{1'b0}}, mem_rdata[HW-1:0]} : mem_rdata;
      fmt_size = req_size;
      fmt_lane = req_addr[1:0];
      fmt_io   = (dec_tgt == TG_IO);
    end
  end

  rgd_rd_fmt #(.DATA_W(DATA_W)) u_fmt (
    .word_i(fmt_word),
    .size_i(fmt_size),
    .lane_i(fmt_lane),
    .io_i  (fmt_io),
    .data_o(fmt_out)
  );

  // memory port
  always_comb begin
    mem_sel   = '0;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_wdata = req_wdata;
    if (busy_q) begin
      mem_sel[TG_IO] = 1'b1;
      mem_addr       = hold_off_q | ADDR_W'(2);
      mem_be         = BE_W'(4'hC);
    end else if (issue) begin
      mem_sel[dec_tgt] = 1'b1;
      mem_addr         = io_split ? (dec_off & ALIGN_MASK) : dec_off;
      mem_we           = req_we;
      mem_be           = be;
    end
  end

  // next state
  always_comb begin
    busy_d      = busy_q;
    hold_off_d  = hold_off_q;
    hold_lane_d = hold_lane_q;
    lo_d        = lo_q;
    rsp_valid_d = 1'b0;
    rsp_rdata_d = rsp_rdata_q;
    rsp_wait_d  = rsp_wait_q;
    rsp_err_d   = rsp_err_q;
    if (busy_q) begin
      busy_d      = 1'b0;
      rsp_valid_d = 1'b1;
      rsp_rdata_d = fmt_out;
      rsp_wait_d  = WAIT_W'(LD_WAIT);
      rsp_err_d   = 1'b0;
    end else if (accept) begin
      if (io_split) begin
        busy_d      = 1'b1;
        hold_off_d  = dec_off & ALIGN_MASK;
        hold_lane_d = req_addr[1:0];
        lo_d        = mem_rdata[HW-1:0];
      end else begin
        rsp_valid_d = 1'b1;
        rsp_wait_d  = req_we ? WAIT_W'(ST_WAIT) : WAIT_W'(LD_WAIT);
        rsp_err_d   = blocked;
        if (req_we)       rsp_rdata_d = '0;
        else if (blocked) rsp_rdata_d = req_fetch ? DATA_W'(TRAP_WORD) : '0;
        else              rsp_rdata_d = fmt_out;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_off_q  <= '0;
      hold_lane_q <= '0;
      lo_q        <= '0;
    end else if (io_split) begin
      hold_off_q  <= hold_off_d;
      hold_lane_q <= hold_lane_d;
      lo_q        <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_rdata_q <= '0;
      rsp_wait_q  <= '0;
      rsp_err_q   <= 1'b0;
    end else if (rsp_valid_d) begin
      rsp_rdata_q <= rsp_rdata_d;
      rsp_wait_q  <= rsp_wait_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign rsp_wait  = rsp_wait_q;
  assign rsp_err   = rsp_err_q;

  // assertions
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(mem_sel));

  a_r2_itcm_limit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_sel[TG_ITCM] |-> (LIM_W'(req_addr) < (LIM_W'(512) << itcm_size_fld)));

  a_r6_split_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_split |=> (!req_ready && !rsp_valid));

  a_r6_split_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_ready |=> (rsp_valid && req_ready));

  a_r12_resp_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !io_split) |=> rsp_valid);

  a_r10_wait_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_wait == (($past(req_we) && !$past(busy_q)) ?
                                WAIT_W'(ST_WAIT) : WAIT_W'(LD_WAIT))));

  a_r11_drop_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> (dec_tgt != TG_NONE && dec_tgt != TG_ROM));
endmodule

// File: tb/addr_region_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_region_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we, req_fetch;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic [4:0]  itcm_size_fld;
  logic [16:0] shr_size;
  logic        rom_present;
  logic [6:0]  mem_sel;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_fetch(req_fetch), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .itcm_size_fld(itcm_size_fld), .shr_size(shr_size),
    .rom_present(rom_present), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_wait(rsp_wait), .rsp_err(rsp_err)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [31:0] pend_hi = '0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  logic [1:0]  q_wait[$];
  string       q_tag[$];

  function automatic logic [31:0] memw(input int t, input logic [31:0] a);
    return {4'(t), a[23:2], 6'h2D};
  endfunction

  function automatic logic [15:0] iohw(input logic [31:0] a);
    return {a[15:1], 1'b0} ^ 16'hC35A;
  endfunction

  function automatic logic [31:0] ror(input logic [31:0] v, input int s);
    logic [63:0] d;
    d = {v, v} >> s;
    return d[31:0];
  endfunction

  // memory fabric model
  always_comb begin
    mem_rdata = 32'h1234_5678;
    for (int i = 0; i < 7; i++)
      if (mem_sel[i]) mem_rdata = (i == 6) ? {16'h0, iohw(mem_addr)} : memw(i, mem_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] sz,
                                           input int t, input logic [31:0] off);
    logic [31:0] w;
    logic [15:0] h;
    if (t == 6) begin
      if (sz == 2) begin
        w = {iohw((off & ~32'd3) | 32'd2), iohw(off & ~32'd3)};
        return ror(w, 8 * a[1:0]);
      end
      h = iohw(off);
      if (sz == 1) return ror({16'h0, h}, 8 * a[0]);
      return {24'h0, a[0] ? h[15:8] : h[7:0]};
    end
    w = memw(t, off);
    if (sz == 2) return ror(w, 8 * a[1:0]);
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 1) return ror({16'h0, h}, 8 * a[0]);
    return {24'h0, 8'(w >> (8 * a[1:0]))};
  endfunction

  // waits out a busy cycle, checking that the split upper half is on the port
  task automatic wait_ready();
    while (!req_ready) begin
      #1;
      chk(mem_sel == 7'h40 && mem_addr == pend_hi && !mem_we,
          "R6 second I/O half while request waits", mem_addr, pend_hi);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input logic f,
                    input int t, input logic [31:0] off, input string tag);
    logic [6:0]  es;
    logic [31:0] ea;
    logic        io_w;
    req_valid = 1; req_we = 0; req_fetch = f; req_size = sz; req_addr = a; req_wdata = '0;
    wait_ready();
    #1;
    io_w = (t == 6 && sz == 2);
    es = (t < 0) ? 7'h0 : 7'(1 << t);
    ea = io_w ? (off & ~32'd3) : off;
    chk(mem_sel == es, {tag, " select"}, 32'(mem_sel), 32'(es));
    if (t >= 0) chk(mem_addr == ea, {tag, " offset"}, mem_addr, ea);
    if (io_w) pend_hi = (off & ~32'd3) | 32'd2;
    if (t < 0) q_data.push_back(f ? 32'hE710_B710 : 32'h0);
    else       q_data.push_back(exp_read(a, sz, t, off));
    q_err.push_back(t < 0);
    q_wait.push_back(2'd2);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                    input int t, input logic [31:0] off, input logic [3:0] ebe, input string tag);
    logic [6:0] es;
    req_valid = 1; req_we = 1; req_fetch = 0; req_size = sz; req_addr = a; req_wdata = d;
    wait_ready();
    #1;
    es = (t < 0) ? 7'h0 : 7'(1 << t);
    chk(mem_sel == es && mem_we == (t >= 0), {tag, " select/strobe"},
        {24'h0, mem_we, mem_sel}, {24'h0, t >= 0, es});
    if (t >= 0) begin
      chk(mem_addr == off, {tag, " offset"}, mem_addr, off);
      chk(mem_be == ebe && mem_wdata == d, {tag, " byte enables"}, {28'h0, mem_be}, {28'h0, ebe});
    end
    q_data.push_back(32'h0);
    q_err.push_back(t < 0);
    q_wait.push_back(2'd1);
    q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        chk(0, "R12 response with nothing expected", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] ed;
        logic        ee;
        logic [1:0]  ew;
        string       et;
        ed = q_data.pop_front(); ee = q_err.pop_front();
        ew = q_wait.pop_front(); et = q_tag.pop_front();
        chk(rsp_rdata == ed, {et, " data"}, rsp_rdata, ed);
        chk(rsp_err == ee, {et, " error flag"}, 32'(rsp_err), 32'(ee));
        chk(rsp_wait == ew, {et, " R10 wait"}, 32'(rsp_wait), 32'(ew));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog expired", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_we = 0; req_fetch = 0; req_size = 0;
    req_addr = '0; req_wdata = '0;
    itcm_size_fld = 5'd6; shr_size = 17'h8000; rom_present = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_sel == 0, "R12 reset state",
        {req_ready, rsp_valid, 30'(mem_sel)}, 32'h8000_0000);

    // R1 R2 instruction TCM window
    rd(32'h0000_1234, 2, 1, 1, 32'h1234, "R1 R2 ITCM fetch");
    rd(32'h0000_7FFC, 2, 0, 1, 32'h7FFC, "R2 ITCM last word");
    rd(32'h0000_8000, 2, 0, -1, 0, "R2 ITCM beyond limit");
    rd(32'h0000_8000, 2, 1, -1, 0, "R9 fetch beyond ITCM limit");
    itcm_size_fld = 5'd16;
    rd(32'h0100_0010, 2, 0, 1, 32'h10, "R1 ITCM mirror code");
    itcm_size_fld = 5'd6;
    // R3 R4 data TCM overlay on main RAM
    rd(32'h027C_0124, 2, 0, 2, 32'h124, "R3 DTCM");
    rd(32'h027C_3FFC, 2, 0, 2, 32'h3FFC, "R3 DTCM top");
    rd(32'h027C_4000, 2, 0, 3, 32'h3C_4000, "R3 R4 past DTCM");
    rd(32'h027B_FFF0, 2, 0, 3, 32'h3B_FFF0, "R4 RAM below DTCM");
    rd(32'h0240_0008, 2, 0, 3, 32'h8, "R4 RAM mirror");
    // R5 working RAM
    rd(32'h0300_9004, 2, 0, 4, 32'h1004, "R5 shared RAM");
    rd(32'h0380_0020, 2, 0, 5, 32'h20, "R5 private RAM");
    shr_size = 17'h0;
    rd(32'h0300_9004, 2, 0, 5, 32'h9004, "R5 shared size zero");
    shr_size = 17'h8000;
    // R6 split I/O word, overlapped with a waiting request
    rd(32'h0400_0132, 2, 0, 6, 32'h132, "R6 R7 I/O word unaligned");
    rd(32'h0200_0103, 2, 0, 3, 32'h103, "R7 RAM word rotate 24");
    rd(32'h0400_0200, 2, 0, 6, 32'h200, "R6 I/O word aligned");
    rd(32'h0400_0207, 1, 0, 6, 32'h207, "R8 I/O half odd");
    rd(32'h0400_0211, 0, 0, 6, 32'h211, "R8 I/O byte");
    // R8 halfword and byte lanes
    rd(32'h0200_0006, 1, 0, 3, 32'h6, "R8 half upper");
    rd(32'h0200_0005, 1, 0, 3, 32'h5, "R8 half rotate");
    rd(32'h0200_0002, 0, 0, 3, 32'h2, "R8 byte lane 2");
    rd(32'h0200_0101, 2, 0, 3, 32'h101, "R7 word rotate 8");
    // R9 R11 boot ROM and unmapped
    rd(32'hFF00_0010, 2, 1, 0, 32'h10, "R1 ROM fetch");
    rom_present = 0;
    rd(32'hFF00_0010, 2, 1, -1, 0, "R9 ROM absent fetch");
    rom_present = 1;
    rd(32'h0500_0000, 2, 1, -1, 0, "R9 invalid region fetch");
    rd(32'h0500_0000, 2, 0, -1, 0, "R11 invalid region read");
    // R10 R11 R13 writes
    wr(32'h0200_0006, 1, 32'hAAAA_5555, 3, 32'h6, 4'hC, "R13 half store");
    wr(32'h0300_0003, 0, 32'h0000_00EE, 4, 32'h3, 4'h8, "R13 byte store");
    wr(32'h0400_0100, 2, 32'hCAFE_F00D, 6, 32'h100, 4'hF, "R13 I/O word store");
    wr(32'h0500_0000, 2, 32'h1111_2222, -1, 0, 4'h0, "R11 unmapped store dropped");
    wr(32'hFF00_0000, 2, 32'h3333_4444, -1, 0, 4'h0, "R11 ROM store dropped");
    req_valid = 0;
    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R12 all responses seen", 32'(q_data.size()), 32'h0);
    finish_run();
  end
endmodule